// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block is the read-out side of a serial configuration memory that feeds a programmable logic device. The device loads itself by pulling bits from such a memory. An internal bit array is walked by an address counter. The bit at the current address is presented on a single data line, and each rising edge of the master clock moves the counter on by one position. Read-out starts at address 0.

Several copies can be chained to hold a longer bitstream. The first copy's enable input comes from the loading device. Each later copy's enable input is the previous copy's enable-out. Once a copy has delivered its last bit, it releases the data line and pulls enable-out low, so the next copy takes over on the next bit with no gap. A reset/output-enable pin with a selectable active level rewinds the counter and restores the hand-off. A power-on wait holds the ready indicator low. A simple parallel write port loads the array while programming mode is selected.

The sequencer has four states:
- `ST_POR_WAIT`: the power-on wait.
- `ST_PROGRAM`: array writes are allowed.
- `ST_STREAM`: serial read-out.
- `ST_EXHAUSTED`: the last bit has been delivered.

The transitions are:
- `ST_POR_WAIT` goes to `ST_STREAM` when the wait ends with `prog_n` high, or to `ST_PROGRAM` when it ends with `prog_n` low.
- `ST_PROGRAM` goes to `ST_STREAM` when `prog_n` rises.
- `ST_STREAM` goes to `ST_PROGRAM` when `prog_n` is low.
- `ST_STREAM` goes to `ST_EXHAUSTED` on the enabled edge that reads the final address.
- `ST_EXHAUSTED` goes to `ST_STREAM` when the reset pin is active.
- `ST_EXHAUSTED` goes to `ST_PROGRAM` when `prog_n` is low.

Tri-state lines are modelled as a value plus an enable. `data_out` reads 0 whenever `data_oe` is low, and `ready_drive` high means the ready line is being pulled low.

Top module: `chain_cfg_rom`

## Requirements
- R1: After `por_n` is released, `ready_drive` stays 1 for exactly POR_CYCLES+1 rising clock edges and then goes to 0. While it is 1, `data_oe` is 0 and `ceo_n` is 1.
- R2: In programming mode (`prog_n` = 0 after the power-on wait), a rising edge with `wr_en` = 1 stores `wr_bit` at `wr_addr`. In this mode `data_oe` is 0 and `ceo_n` is 1. Raising `prog_n` restarts read-out at address 0.
- R3: `wr_en` has no effect on the array while `prog_n` = 1.
- R4: In read-out, with `ce_n` = 0 and the reset pin inactive, `data_oe` = 1 and `data_out` equals the stored bit at the current address. The address starts at 0 and advances by one on each rising edge.
- R5: While `ce_n` = 1, `data_oe` is 0. With the reset pin inactive, the address does not move, so read-out resumes at the same bit when `ce_n` returns to 0.
- R6: After the rising edge that reads address DEPTH-1, `ceo_n` is 0 and `data_oe` is 0. Both hold for any number of clocks while the reset pin stays inactive.
- R7: The reset pin is active when `rst_oe` equals `rst_pol`: `rst_pol` = 0 gives active-low and `rst_pol` = 1 gives active-high. While the pin is active, `data_oe` is 0. The next rising edge sets the address to 0 and `ceo_n` to 1, both mid-stream and after exhaustion.
- R8: In a chain where each copy's `ce_n` is the previous copy's `ceo_n`, the bits of the second copy follow the bits of the first with no missing or repeated clock, and at most one copy has `data_oe` = 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master serial clock; everything advances on its rising edge |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| rst_oe | input | 1 | Reset/output-enable pin |
| rst_pol | input | 1 | Active level of `rst_oe` (0: low-active, 1: high-active) |
| prog_n | input | 1 | 0 selects programming mode, 1 selects serial read-out |
| wr_en | input | 1 | Array write strobe, honoured only in programming mode |
| wr_addr | input | $clog2(DEPTH) | Array location to write |
| wr_bit | input | 1 | Value to write |
| data_out | output | 1 | Serial data value, 0 when not driven |
| data_oe | output | 1 | 1 when this copy drives the data line |
| ceo_n | output | 1 | Enable-out to the next copy, low after the last bit |
| ready_drive | output | 1 | 1 while the ready line is pulled low (power-on wait) |

## Verification
Two copies are chained, and each array is filled with several arithmetic bit patterns that differ between copies. This shows whether the bits come from the right copy, whether they come in address order, and whether the hand-off slips or repeats a clock. Some reads are broken up by a standby pause, by a mid-stream rewind or by a switch into programming mode. These separate a counter that freezes from one that keeps counting or restarts. Both reset polarities are used, so an inverted level decode shows up as a missed or spurious rewind. A write strobe pulsed outside programming mode, followed by a full re-read, exposes writes that leak past the mode gate.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
    typedef enum logic [1:0] {
        ST_POR_WAIT  = 2'd0,
        ST_PROGRAM   = 2'd1,
        ST_STREAM    = 2'd2,
        ST_EXHAUSTED = 2'd3
    } cfg_state_e;
endpackage

// File: rtl/cfgrom_por_timer.sv
module cfgrom_por_timer #(
    parameter int unsigned POR_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    output logic por_done
);
    localparam int unsigned CW = $clog2(POR_CYCLES + 2);

    logic [CW-1:0] wait_cnt;

    // Count up once per clock after power-on, then saturate at POR_CYCLES.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wait_cnt <= '0;
        end else if (wait_cnt != CW'(POR_CYCLES)) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign por_done = (wait_cnt == CW'(POR_CYCLES));
endmodule

// File: rtl/cfgrom_bit_store.sv
module cfgrom_bit_store #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    logic [DEPTH-1:0] cells;

    // One storage flop per location; no reset, the contents model a
    // non-volatile array.
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(g))) begin
                cells[g] <= wr_bit;
            end
        end
    end

    assign rd_bit = cells[rd_addr];
endmodule

// File: rtl/cfgrom_read_fsm.sv
module cfgrom_read_fsm
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          por_done,
    input  logic          ce_n,
    input  logic          rst_hit,
    input  logic          prog_n,
    output cfg_state_e    state,
    output logic [AW-1:0] rd_addr,
    output logic          data_oe,
    output logic          ceo_n,
    output logic          ready_drive,
    output logic          wr_allow
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    cfg_state_e    state_nxt;
    logic [AW-1:0] addr_nxt;
    logic          at_last;

    assign at_last = (rd_addr == LAST_ADDR);

    // Next state and next address.
    always_comb begin
        state_nxt = state;
        addr_nxt  = rd_addr;
        unique case (state)
            ST_POR_WAIT: begin
                addr_nxt = '0;
                if (por_done) begin
                    state_nxt = prog_n ? ST_STREAM : ST_PROGRAM;
                end
            end
            ST_PROGRAM: begin
                addr_nxt = '0;
                if (prog_n) begin
                    state_nxt = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (!prog_n) begin
                    state_nxt = ST_PROGRAM;
                    addr_nxt  = '0;
                end else if (rst_hit) begin
                    addr_nxt = '0;
                end else if (!ce_n) begin
                    if (at_last) begin
                        state_nxt = ST_EXHAUSTED;
                    end else begin
                        addr_nxt = rd_addr + 1'b1;
                    end
                end
            end
            ST_EXHAUSTED: begin
                if (!prog_n) begin
                    state_nxt = ST_PROGRAM;
                    addr_nxt  = '0;
                end else if (rst_hit) begin
                    state_nxt = ST_STREAM;
                    addr_nxt  = '0;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state   <= ST_POR_WAIT;
            rd_addr <= '0;
        end else begin
            state   <= state_nxt;
            rd_addr <= addr_nxt;
        end
    end

    // Outputs.
    always_comb begin
        data_oe     = 1'b0;
        ceo_n       = 1'b1;
        ready_drive = 1'b0;
        wr_allow    = 1'b0;
        unique case (state)
            ST_POR_WAIT:  ready_drive = 1'b1;
            ST_PROGRAM:   wr_allow    = !prog_n;
            ST_STREAM:    data_oe     = !ce_n && !rst_hit && prog_n;
            ST_EXHAUSTED: ceo_n       = 1'b0;
        endcase
    end
endmodule

// File: rtl/chain_cfg_rom.sv
module chain_cfg_rom
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH      = 256,
    parameter int unsigned POR_CYCLES = 16,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          ce_n,
    input  logic          rst_oe,
    input  logic          rst_pol,
    input  logic          prog_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    output logic          data_out,
    output logic          data_oe,
    output logic          ceo_n,
    output logic          ready_drive
);
    cfg_state_e    cur_state;
    logic [AW-1:0] rd_addr;
    logic          por_done;
    logic          rst_hit;
    logic          wr_allow;
    logic          rd_bit;

    // The reset pin counts as active when it sits at the selected level.
    assign rst_hit = (rst_oe == rst_pol);

    cfgrom_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk      (clk),
        .por_n    (por_n),
        .por_done (por_done)
    );

    cfgrom_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en && wr_allow),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

    cfgrom_read_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .por_done    (por_done),
        .ce_n        (ce_n),
        .rst_hit     (rst_hit),
        .prog_n      (prog_n),
        .state       (cur_state),
        .rd_addr     (rd_addr),
        .data_oe     (data_oe),
        .ceo_n       (ceo_n),
        .ready_drive (ready_drive),
        .wr_allow    (wr_allow)
    );

    assign data_out = data_oe & rd_bit;
endmodule

// File: rtl/chain_cfg_rom_chk.sv
module chain_cfg_rom_chk
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          por_n,
    input logic          ce_n,
    input logic          rst_oe,
    input logic          rst_pol,
    input logic          prog_n,
    input logic          data_oe,
    input logic          ceo_n,
    input logic          ready_drive,
    input cfg_state_e    cur_state,
    input logic [AW-1:0] rd_addr
);
    logic rst_act;
    assign rst_act = (rst_oe == rst_pol);

    // R1: nothing is driven during the power-on wait.
    p_quiet_por_r1: assert property (@(posedge clk) disable iff (!por_n)
        ready_drive |-> (!data_oe && ceo_n));

    // R2: programming mode keeps the data line released.
    p_prog_silent_r2: assert property (@(posedge clk) disable iff (!por_n)
        !prog_n |-> !data_oe);

    // R4: an enabled edge moves the address on by one.
    p_step_r4: assert property (@(posedge clk) disable iff (!por_n)
        (cur_state == ST_STREAM && !ce_n && prog_n && !rst_act && rd_addr != AW'(DEPTH - 1))
        |=> (rd_addr == AW'($past(rd_addr) + 1)));

    // R5: standby releases the line.
    p_standby_off_r5: assert property (@(posedge clk) disable iff (!por_n)
        ce_n |-> !data_oe);

    // R5: standby freezes the address.
    p_standby_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        (cur_state == ST_STREAM && ce_n && prog_n && !rst_act)
        |=> (rd_addr == $past(rd_addr)));

    // R6: after hand-off this copy no longer drives.
    p_handoff_off_r6: assert property (@(posedge clk) disable iff (!por_n)
        !ceo_n |-> !data_oe);

    // R6: the hand-off holds while the reset pin is idle.
    p_handoff_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!ceo_n && prog_n && !rst_act) |=> !ceo_n);

    // R7: an active reset pin rewinds the address.
    p_rewind_r7: assert property (@(posedge clk) disable iff (!por_n)
        (rst_act && prog_n && !ready_drive) |=> (rd_addr == '0 && ceo_n));
endmodule

bind chain_cfg_rom chain_cfg_rom_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .ce_n        (ce_n),
    .rst_oe      (rst_oe),
    .rst_pol     (rst_pol),
    .prog_n      (prog_n),
    .data_oe     (data_oe),
    .ceo_n       (ceo_n),
    .ready_drive (ready_drive),
    .cur_state   (cur_state),
    .rd_addr     (rd_addr)
);

// File: tb/chain_cfg_rom_bench.sv
`timescale 1ns/1ps
module chain_cfg_rom_bench;
    localparam int DEPTH = 16;
    localparam int PORC  = 4;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          por_n, ce_n, rst_oe, rst_pol, prog_n;
    logic          wr_en0, wr_en1, wr_bit;
    logic [AW-1:0] wr_addr;
    logic          d0, oe0, ceo0, rdy0;
    logic          d1, oe1, ceo1, rdy1;
    logic          bus;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    chain_cfg_rom #(.DEPTH(DEPTH), .POR_CYCLES(PORC)) u_chain_cfg_rom (
        .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_oe), .rst_pol(rst_pol),
        .prog_n(prog_n), .wr_en(wr_en0), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .data_out(d0), .data_oe(oe0), .ceo_n(ceo0), .ready_drive(rdy0)
    );

    chain_cfg_rom #(.DEPTH(DEPTH), .POR_CYCLES(PORC)) u_chain_cfg_rom_b (
        .clk(clk), .por_n(por_n), .ce_n(ceo0), .rst_oe(rst_oe), .rst_pol(rst_pol),
        .prog_n(prog_n), .wr_en(wr_en1), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .data_out(d1), .data_oe(oe1), .ceo_n(ceo1), .ready_drive(rdy1)
    );

    assign bus = oe0 ? d0 : d1;

    function automatic logic pat(int dev, int i, int seed);
        return ((i * i + i * (seed + 1) + dev * 7 + seed * 3) % 5) >= 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic program_both(int seed);
        @(negedge clk);
        check("R2 prog oe0", oe0, 0);
        check("R2 prog ceo0", ceo0, 1);
        for (int dev = 0; dev < 2; dev++) begin
            for (int i = 0; i < DEPTH; i++) begin
                wr_addr = AW'(i);
                wr_bit  = pat(dev, i, seed);
                wr_en0  = (dev == 0);
                wr_en1  = (dev == 1);
                @(negedge clk);
            end
        end
        wr_en0 = 1'b0;
        wr_en1 = 1'b0;
    endtask

    // Both copies sit at address 0 in read-out; the caller is just past a
    // falling edge. Read the whole chain, optionally pausing at bit stall_at.
    task automatic read_chain(int seed, int stall_at, string tag);
        for (int k = 0; k < 2 * DEPTH; k++) begin
            int dev = (k < DEPTH) ? 0 : 1;
            int idx = k % DEPTH;
            if (k == stall_at) begin
                ce_n = 1'b1;
                for (int s = 0; s < 3; s++) begin
                    #1;
                    check({tag, " R5 standby oe0"}, oe0, 0);
                    check({tag, " R5 standby oe1"}, oe1, 0);
                    @(negedge clk);
                end
                ce_n = 1'b0;
                #1;
            end
            check({tag, " R4 oe0"}, oe0, (dev == 0) ? 1 : 0);
            check({tag, " R8 oe1"}, oe1, (dev == 1) ? 1 : 0);
            check({tag, " R4 R8 bit"}, bus, pat(dev, idx, seed));
            @(negedge clk);
        end
        check({tag, " R6 oe0"}, oe0, 0);
        check({tag, " R6 oe1"}, oe1, 0);
        check({tag, " R6 ceo0"}, ceo0, 0);
        check({tag, " R6 ceo1"}, ceo1, 0);
        repeat (5) @(negedge clk);
        check({tag, " R6 hold ceo1"}, ceo1, 0);
        check({tag, " R6 hold oe0"}, oe0, 0);
    endtask

    task automatic start_read();
        prog_n = 1'b1;
        ce_n   = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        if (!finished) $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        por_n = 1'b0; ce_n = 1'b1; rst_pol = 1'b0; rst_oe = 1'b1;
        prog_n = 1'b0; wr_en0 = 1'b0; wr_en1 = 1'b0; wr_bit = 1'b0; wr_addr = '0;
        repeat (2) @(negedge clk);
        check("R1 reset ready", rdy0, 1);
        check("R1 reset oe", oe0, 0);
        check("R1 reset ceo", ceo0, 1);
        por_n = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (rdy0) begin
                check("R1 wait oe", oe0, 0);
                check("R1 wait ceo", ceo0, 1);
            end
        end while (rdy0 && cnt < 100);
        check("R1 wait length", cnt, PORC + 1);
        check("R1 ready second copy", rdy1, 0);

        // R2: load, then leaving programming mode restarts at address 0.
        program_both(0);
        start_read();
        read_chain(0, 5, "seed0");

        // R3: write strobes outside programming mode are ignored.
        wr_addr = AW'(3); wr_bit = !pat(0, 3, 0); wr_en0 = 1'b1; wr_en1 = 1'b1;
        repeat (2) @(negedge clk);
        wr_en0 = 1'b0; wr_en1 = 1'b0;

        // R7 with active-low polarity after exhaustion.
        rst_oe = 1'b0;
        @(negedge clk);
        check("R7 low active oe0", oe0, 0);
        check("R7 low rewind ceo0", ceo0, 1);
        check("R7 low rewind ceo1", ceo1, 1);
        rst_oe = 1'b1;
        #1;
        read_chain(0, -1, "R3 reread");

        // R7 with active-high polarity, mid-stream rewind.
        rst_pol = 1'b1; rst_oe = 1'b0;
        @(negedge clk);
        check("R7 high idle keeps ceo0", ceo0, 0);
        rst_oe = 1'b1;
        @(negedge clk);
        check("R7 high rewind ceo0", ceo0, 1);
        check("R7 high active oe0", oe0, 0);
        rst_oe = 1'b0;
        #1;
        repeat (7) @(negedge clk);
        rst_oe = 1'b1;
        @(negedge clk);
        check("R7 mid active oe0", oe0, 0);
        rst_oe = 1'b0;
        #1;
        read_chain(0, -1, "R7 midrewind");

        // R2: switching to programming mode mid-stream; new patterns.
        for (int seed = 1; seed < 4; seed++) begin
            rst_oe = 1'b1;
            @(negedge clk);
            rst_oe = 1'b0;
            #1;
            repeat (seed + 2) @(negedge clk);
            prog_n = 1'b0;
            #1;
            check("R2 midstream prog oe0", oe0, 0);
            program_both(seed);
            start_read();
            read_chain(seed, (seed * 4) % DEPTH, "multi seed");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule